// File: doc/BRIEF.md
# Address-Data Framed Serial Port

This block is the serial link between a converter front end and a host DSP. Every transfer in either direction is a pair of words: a 16-bit address word followed by a 16-bit data word. Each word is introduced by its own one-cycle frame sync. Bits travel most significant first.

Toward the host, two internal producers offer words: the ADC and the interpolator. Each has a one-word pending slot. A fixed-priority arbiter picks the ADC slot first and never breaks into a pair that is already being sent. Each pair carries a fixed per-source address. Nothing is sent until the digital power-up control input is high. A producer that writes into a slot that is still full replaces the old word and raises a sticky overrun flag.

From the host, the block samples frame sync and data on the falling clock edge. It assembles the address and data words and then emits a one-cycle write strobe. The strobe carries the low address bits as a holding-register select, together with the data word. The core then reads that register whenever it needs the value.

Top module: `afe_sport`

## Requirements
- R1: While `pwr_up` is 0 no output frame sync is produced. Words that arrive in that time stay pending. When `pwr_up` rises with a word pending, `fs_out` goes high right after the next rising clock edge.
- R2: An output pair has a fixed shape. First `fs_out` is high for one cycle. Then come 16 address bits on `sd_out`, MSB first, one per cycle. Then `fs_out` is high for one more cycle, followed by 16 data bits, MSB first. `sd_out` is 0 during frame-sync and idle cycles. ADC pairs carry address `ADC_ADDR` (default 0x0002) and interpolator pairs carry `ITP_ADDR` (default 0x0001).
- R3: When both slots are pending at a start decision, the ADC word is sent first.
- R4: A word that becomes pending during a pair is not sent until that pair's data LSB has gone out. If it was already pending, its frame sync follows 34 cycles after the previous pair's first frame sync.
- R5: Loading a slot that is still pending replaces its word, so only the newer word is sent. It also sets that source's overrun bit (`ovr[0]` ADC, `ovr[1]` interpolator), which stays set until reset.
- R6: `fs_in` is sampled on the falling edge. The MSB of the word is captured on the falling edge one cycle later, and the remaining 15 bits on the following falling edges. The first word after idle is the address.
- R7: The data word's frame sync is accepted in the address LSB cycle, which gives back-to-back words. It is also accepted in any later cycle.
- R8: `fs_in` high at any falling edge inside a word other than the LSB edge has no effect on the received pair.
- R9: After the falling edge that captures the data LSB, `wr_en` is high for exactly one cycle. During that cycle `wr_sel` holds the address word's low 4 bits and `wr_data` holds the data word.
- R10: After reset, `fs_out`, `sd_out`, `wr_en` and `ovr` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock; output changes on the rising edge, input is sampled on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_up | input | 1 | Digital power-up control; the output side is idle while 0 |
| adc_vld | input | 1 | ADC word valid, one rising edge per word |
| adc_word | input | 16 | ADC result word |
| itp_vld | input | 1 | Interpolator word valid |
| itp_word | input | 16 | Interpolator result word |
| ovr | output | 2 | Sticky overrun flags (bit 0 ADC, bit 1 interpolator) |
| fs_out | output | 1 | Output frame sync |
| sd_out | output | 1 | Output serial data |
| fs_in | input | 1 | Host frame sync |
| sd_in | input | 1 | Host serial data |
| wr_en | output | 1 | One-cycle holding-register write strobe |
| wr_sel | output | 4 | Holding-register select (address low bits) |
| wr_data | output | 16 | Received data word |

## Verification
On the output side, a rising clock edge first registers a producer's valid pulse into its slot. The next rising edge raises the frame sync, and each following edge presents one bit. For that reason the bench's monitor samples on falling edges and records the cycle of every frame sync. This lets it compare the first sync against the cycle after `pwr_up` rises, and back-to-back pairs against a 34-cycle spacing. On the input side the bench drives each bit just after a rising edge so that the same cycle's falling edge captures it. It looks for the strobe just after the rising edge that follows the data LSB, and one cycle later it checks that the strobe has dropped.

// File: rtl/afe_sport_pkg.sv
package afe_sport_pkg;

   typedef enum logic [1:0] {
      TX_IDLE = 2'd0,
      TX_ADDR = 2'd1,
      TX_FSD  = 2'd2,
      TX_DATA = 2'd3
   } tx_st_e;

endpackage

// File: rtl/afe_sport_slot.sv
module afe_sport_slot #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         take,
   input  logic [W-1:0] din,
   output logic         pend,
   output logic [W-1:0] dout,
   output logic         ovr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
         dout <= '0;
         ovr  <= 1'b0;
      end else begin
         if (load) dout <= din;
         pend <= load | (pend & ~take);
         if (load & pend & ~take) ovr <= 1'b1;
      end
   end

   // R5: overrun flag is sticky
   a_r5_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovr |=> ovr);

endmodule

// File: rtl/afe_sport_tx.sv
module afe_sport_tx
   import afe_sport_pkg::*;
#(
   parameter int W    = 16,
   parameter int NSRC = 2,
   parameter logic [NSRC*W-1:0] ADDRS = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_up,
   input  logic [NSRC-1:0]   pend,
   input  logic [NSRC*W-1:0] words,
   output logic [NSRC-1:0]   take,
   output logic              fs_out,
   output logic              sd_out
);

   localparam int CNT_W = $clog2(W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

   tx_st_e            st;
   logic [CNT_W-1:0]  cnt;
   logic [W-1:0]      sh, dq;
   logic [NSRC-1:0]   grant;
   logic [W-1:0]      sel_a, sel_d;

   always_comb begin
      grant = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (pend[i]) begin
            grant    = '0;
            grant[i] = 1'b1;
         end
      end
      sel_a = '0;
      sel_d = '0;
      for (int i = 0; i < NSRC; i++) begin
         if (grant[i]) begin
            sel_a = sel_a | ADDRS[i*W +: W];
            sel_d = sel_d | words[i*W +: W];
         end
      end
      take = (st == TX_IDLE && pwr_up) ? grant : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= TX_IDLE;
         cnt    <= '0;
         sh     <= '0;
         dq     <= '0;
         fs_out <= 1'b0;
         sd_out <= 1'b0;
      end else begin
         fs_out <= 1'b0;
         unique case (st)
            TX_IDLE: begin
               sd_out <= 1'b0;
               if (|take) begin
                  fs_out <= 1'b1;
                  sh     <= sel_a;
                  dq     <= sel_d;
                  cnt    <= '0;
                  st     <= TX_ADDR;
               end
            end
            TX_ADDR, TX_DATA: begin
               sd_out <= sh[W-1];
               sh     <= {sh[W-2:0], 1'b0};
               cnt    <= cnt + CNT_W'(1);
               if (cnt == LAST) st <= (st == TX_ADDR) ? TX_FSD : TX_IDLE;
            end
            TX_FSD: begin
               sd_out <= 1'b0;
               fs_out <= 1'b1;
               sh     <= dq;
               cnt    <= '0;
               st     <= TX_DATA;
            end
            default: st <= TX_IDLE;
         endcase
      end
   end

   // R2: each frame sync lasts a single cycle
   a_r2_fs_single: assert property (@(posedge clk) disable iff (!rst_n)
      fs_out |=> !fs_out);

   // R1: no frame sync from idle while powered down
   a_r1_idle_down: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwr_up && st == TX_IDLE) |=> !fs_out);

   // R3: a lower-priority slot is taken only when all higher ones are empty
   for (genvar i = 1; i < NSRC; i++) begin : g_pri
      a_r3_priority: assert property (@(posedge clk) disable iff (!rst_n)
         take[i] |-> (pend[i-1:0] == '0));
   end

endmodule

// File: rtl/afe_sport_rx.sv
module afe_sport_rx #(
   parameter int W     = 16,
   parameter int SEL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fs_in,
   input  logic             sd_in,
   output logic             wr_en,
   output logic [SEL_W-1:0] wr_sel,
   output logic [W-1:0]     wr_data
);

   localparam int CNT_W = $clog2(W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

   logic             busy, have_addr;
   logic [CNT_W-1:0] cnt;
   logic [W-1:0]     sh, addr_q;
   logic [W-1:0]     full;

   assign full = {sh[W-2:0], sd_in};

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         have_addr <= 1'b0;
         cnt       <= '0;
         sh        <= '0;
         addr_q    <= '0;
         wr_en     <= 1'b0;
         wr_sel    <= '0;
         wr_data   <= '0;
      end else begin
         wr_en <= 1'b0;
         if (busy) begin
            sh  <= full;
            cnt <= cnt + CNT_W'(1);
            if (cnt == LAST) begin
               busy <= fs_in;
               cnt  <= '0;
               if (!have_addr) begin
                  addr_q    <= full;
                  have_addr <= 1'b1;
               end else begin
                  wr_en     <= 1'b1;
                  wr_sel    <= addr_q[SEL_W-1:0];
                  wr_data   <= full;
                  have_addr <= 1'b0;
               end
            end
         end else if (fs_in) begin
            busy <= 1'b1;
            cnt  <= '0;
         end
      end
   end

   // R9: write strobe lasts one cycle
   a_r9_wr_pulse: assert property (@(negedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   // R6: a word starts only from a recognised frame sync
   a_r6_start: assert property (@(negedge clk) disable iff (!rst_n)
      (!busy && !fs_in) |=> !busy);

endmodule

// File: rtl/afe_sport.sv
module afe_sport #(
   parameter int WORD_W = 16,
   parameter int SEL_W  = 4,
   parameter logic [WORD_W-1:0] ADC_ADDR = 16'h0002,
   parameter logic [WORD_W-1:0] ITP_ADDR = 16'h0001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_up,
   input  logic              adc_vld,
   input  logic [WORD_W-1:0] adc_word,
   input  logic              itp_vld,
   input  logic [WORD_W-1:0] itp_word,
   output logic [1:0]        ovr,
   output logic              fs_out,
   output logic              sd_out,
   input  logic              fs_in,
   input  logic              sd_in,
   output logic              wr_en,
   output logic [SEL_W-1:0]  wr_sel,
   output logic [WORD_W-1:0] wr_data
);

   localparam int NSRC = 2;
   localparam logic [NSRC*WORD_W-1:0] ADDRS = {ITP_ADDR, ADC_ADDR};

   if (WORD_W < 4) begin : g_bad_w
      $error("WORD_W too small");
   end
   if (SEL_W < 1 || SEL_W > WORD_W) begin : g_bad_sel
      $error("SEL_W out of range");
   end

   logic [NSRC-1:0]        src_vld, pend, take;
   logic [NSRC*WORD_W-1:0] src_word, held;

   assign src_vld  = {itp_vld, adc_vld};
   assign src_word = {itp_word, adc_word};

   for (genvar i = 0; i < NSRC; i++) begin : g_slot
      afe_sport_slot #(.W(WORD_W)) u_slot (
         .clk  (clk),
         .rst_n(rst_n),
         .load (src_vld[i]),
         .take (take[i]),
         .din  (src_word[i*WORD_W +: WORD_W]),
         .pend (pend[i]),
         .dout (held[i*WORD_W +: WORD_W]),
         .ovr  (ovr[i])
      );
   end

   afe_sport_tx #(.W(WORD_W), .NSRC(NSRC), .ADDRS(ADDRS)) u_tx (
      .clk   (clk),
      .rst_n (rst_n),
      .pwr_up(pwr_up),
      .pend  (pend),
      .words (held),
      .take  (take),
      .fs_out(fs_out),
      .sd_out(sd_out)
   );

   afe_sport_rx #(.W(WORD_W), .SEL_W(SEL_W)) u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .fs_in  (fs_in),
      .sd_in  (sd_in),
      .wr_en  (wr_en),
      .wr_sel (wr_sel),
      .wr_data(wr_data)
   );

endmodule

// File: tb/tb_afe_sport.sv
`timescale 1ns/1ps
module tb_afe_sport;

   localparam logic [15:0] ADC_A = 16'h0002;
   localparam logic [15:0] ITP_A = 16'h0001;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pwr_up = 1'b0;
   logic        adc_vld = 1'b0, itp_vld = 1'b0;
   logic [15:0] adc_word = '0, itp_word = '0;
   logic [1:0]  ovr;
   logic        fs_out, sd_out;
   logic        fs_in = 1'b0, sd_in = 1'b0;
   logic        wr_en;
   logic [3:0]  wr_sel;
   logic [15:0] wr_data;

   always #10 clk = ~clk;

   afe_sport dut (
      .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up),
      .adc_vld(adc_vld), .adc_word(adc_word),
      .itp_vld(itp_vld), .itp_word(itp_word),
      .ovr(ovr), .fs_out(fs_out), .sd_out(sd_out),
      .fs_in(fs_in), .sd_in(sd_in),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data)
   );

   int checks = 0;
   int errs = 0;
   int mon_err = 0;
   int cyc = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // output-side monitor
   logic [15:0] m_addr [0:63];
   logic [15:0] m_data [0:63];
   int          m_cyc  [0:63];
   int          m_n = 0;
   int          mst = 0;
   int          mbits = 0;
   logic [15:0] msh = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         case (mst)
            0: if (fs_out) begin
                  m_cyc[m_n % 64] = cyc;
                  mst = 1; mbits = 0;
               end
            1, 3: begin
               if (fs_out) begin
                  mon_err++;
                  $display("FAIL R2: frame sync inside word, act=1 exp=0");
               end
               msh = {msh[14:0], sd_out};
               mbits++;
               if (mbits == 16) begin
                  if (mst == 1) begin
                     m_addr[m_n % 64] = msh;
                     mst = 2;
                  end else begin
                     m_data[m_n % 64] = msh;
                     m_n++;
                     mst = 0;
                  end
                  mbits = 0;
               end
            end
            2: begin
               if (!fs_out || sd_out) begin
                  mon_err++;
                  $display("FAIL R2: data frame sync act=%0b sd=%0b exp=1/0", fs_out, sd_out);
               end
               mst = 3;
            end
            default: mst = 0;
         endcase
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] src_addr(input bit itp);
      return itp ? ITP_A : ADC_A;
   endfunction

   task automatic push(input bit itp, input logic [15:0] w);
      @(negedge clk);
      if (itp) begin itp_vld = 1'b1; itp_word = w; end
      else     begin adc_vld = 1'b1; adc_word = w; end
      @(negedge clk);
      adc_vld = 1'b0; itp_vld = 1'b0;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_pair(input int idx, input bit itp, input logic [15:0] d, input string req);
      chk(m_addr[idx % 64] == src_addr(itp), req, m_addr[idx % 64], src_addr(itp));
      chk(m_data[idx % 64] == d, req, m_data[idx % 64], d);
   endtask

   // host writes one pair; early: data sync in addr LSB cycle; gap: idle cycles otherwise
   task automatic host_pair(input logic [15:0] a, input logic [15:0] d,
                            input bit early, input int gap, input bit junk);
      @(posedge clk); #2 fs_in = 1'b1; sd_in = 1'b0;
      for (int i = 15; i >= 0; i--) begin
         @(posedge clk); #2;
         fs_in = (junk && i == 8) || (early && i == 0);
         sd_in = a[i];
      end
      if (!early) begin
         for (int g = 0; g < gap; g++) begin
            @(posedge clk); #2 fs_in = 1'b0; sd_in = 1'b0;
         end
         @(posedge clk); #2 fs_in = 1'b1; sd_in = 1'b0;
      end
      for (int i = 15; i >= 0; i--) begin
         @(posedge clk); #2;
         fs_in = (junk && i == 5);
         sd_in = d[i];
      end
      @(posedge clk); #2 fs_in = 1'b0; sd_in = 1'b0;
      chk(wr_en === 1'b1, "R9 strobe", {31'd0, wr_en}, 32'd1);
      chk(wr_sel == a[3:0], early ? "R7 sel" : (junk ? "R8 sel" : "R6 sel"), {28'd0, wr_sel}, {28'd0, a[3:0]});
      chk(wr_data == d, early ? "R7 data" : (junk ? "R8 data" : "R6 data"), {16'd0, wr_data}, {16'd0, d});
      @(posedge clk); #2;
      chk(wr_en === 1'b0, "R9 one cycle", {31'd0, wr_en}, 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog: act=timeout exp=done");
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errs + mon_err + 1);
      $finish;
   end

   initial begin
      int b, c, seed;
      seed = $urandom(32'h5eed);
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(fs_out === 1'b0 && sd_out === 1'b0, "R10 tx", {30'd0, fs_out, sd_out}, 32'd0);
      chk(wr_en === 1'b0, "R10 wr_en", {31'd0, wr_en}, 32'd0);
      chk(ovr === 2'b00, "R10 ovr", {30'd0, ovr}, 32'd0);
      rst_n = 1'b1;
      wait_cyc(2);

      // R1: held while powered down, starts one edge after power-up
      push(1'b0, 16'hA5C3);
      wait_cyc(40);
      chk(m_n == 0, "R1 idle", m_n, 0);
      b = m_n;
      c = cyc;
      pwr_up = 1'b1;
      wait_cyc(40);
      chk(m_n == b + 1, "R1 count", m_n, b + 1);
      chk(m_cyc[b % 64] == c + 1, "R1 start cycle", m_cyc[b % 64], c + 1);
      chk_pair(b, 1'b0, 16'hA5C3, "R2 pair");

      // R3: both pending, ADC first; R4 back-to-back spacing
      pwr_up = 1'b0;
      push(1'b1, 16'h1234);
      push(1'b0, 16'hBEEF);
      b = m_n;
      pwr_up = 1'b1;
      wait_cyc(80);
      chk(m_n == b + 2, "R3 count", m_n, b + 2);
      chk_pair(b, 1'b0, 16'hBEEF, "R3 first");
      chk_pair(b + 1, 1'b1, 16'h1234, "R3 second");
      chk(m_cyc[(b + 1) % 64] == m_cyc[b % 64] + 34, "R4 spacing",
          m_cyc[(b + 1) % 64], m_cyc[b % 64] + 34);

      // R4: ADC arriving mid-pair waits
      b = m_n;
      push(1'b1, 16'h0F0F);
      wait_cyc(5);
      push(1'b0, 16'h7777);
      wait_cyc(80);
      chk(m_n == b + 2, "R4 count", m_n, b + 2);
      chk_pair(b, 1'b1, 16'h0F0F, "R4 no preempt");
      chk_pair(b + 1, 1'b0, 16'h7777, "R4 after");
      chk(m_cyc[(b + 1) % 64] == m_cyc[b % 64] + 34, "R4 wait",
          m_cyc[(b + 1) % 64], m_cyc[b % 64] + 34);

      // R5: overrun replaces and flags
      chk(ovr == 2'b00, "R5 clear", {30'd0, ovr}, 32'd0);
      pwr_up = 1'b0;
      push(1'b0, 16'h1111);
      push(1'b0, 16'h2222);
      chk(ovr == 2'b01, "R5 flag", {30'd0, ovr}, 32'd1);
      b = m_n;
      pwr_up = 1'b1;
      wait_cyc(80);
      chk(m_n == b + 1, "R5 single", m_n, b + 1);
      chk_pair(b, 1'b0, 16'h2222, "R5 newer");
      chk(ovr == 2'b01, "R5 sticky", {30'd0, ovr}, 32'd1);

      // random output words
      for (int k = 0; k < 20; k++) begin
         bit s;
         logic [15:0] w;
         s = 1'($urandom);
         w = 16'($urandom);
         b = m_n;
         push(s, w);
         wait_cyc(40 + int'($urandom % 4));
         chk(m_n == b + 1, "R2 rand count", m_n, b + 1);
         chk_pair(b, s, w, "R2 rand");
      end

      // directed host writes
      host_pair(16'h00A7, 16'h8001, 1'b0, 0, 1'b0);
      host_pair(16'hFFF3, 16'h5AA5, 1'b1, 0, 1'b0);
      host_pair(16'h123C, 16'hC0DE, 1'b0, 3, 1'b1);
      host_pair(16'h0005, 16'hFFFF, 1'b1, 0, 1'b1);
      // random host writes
      for (int k = 0; k < 30; k++) begin
         host_pair(16'($urandom), 16'($urandom), 1'($urandom), int'($urandom % 4), 1'($urandom));
         repeat (int'($urandom % 3)) @(posedge clk);
      end

      wait_cyc(2);
      $display("Simulation finished: %0d checks, %0d errors", checks, errs + mon_err);
      $finish;
   end

endmodule